// File: doc/BRIEF.md
# Register File with Stepping Index Registers

This block is the sixteen-entry architectural register file of a small accumulator datapath. Entry 0 serves as the accumulator and entries 1 to 7 are plain general-purpose storage. Entries 8 to 13 are index registers: 8, 9 and 10 count down by one and 11, 12 and 13 count up by one when stepped. Entry 14 is the link register. Entry 15 is the flags word, which carries a done bit and a zero bit.

The datapath reads any entry through a combinational read port and writes any entry through a single write port on the rising clock edge. A separate step port takes a 3-bit selector whose implied top address bit is 1, so it reaches entries 8 to 15. It advances the selected index register in place, without a read-modify-write through the datapath.

The done bit is a two-state machine. `DS_RUNNING` moves to `DS_FINISHED` on the transition GO_HALT, which a done strobe or a flags write with bit 7 set produces. `DS_FINISHED` moves back to `DS_RUNNING` on the transition GO_RUN, which the external start pulse or a flags write with bit 7 clear produces. The zero bit has its own update input from the ALU.

Top module: `idxreg_file`

## Requirements
- R1: After reset, all sixteen entries read 0x00, and `done_o` and `zero_o` are 0.
- R2: A write with `wr_en` high stores `wr_data` into entries 0 to 14 at the next rising edge. `rd_data` shows entry `rd_addr` combinationally.
- R3: Entries 8, 9 and 10 decrease by one when stepped and wrap from 0x00 to 0xFF.
- R4: Entries 11, 12 and 13 increase by one when stepped and wrap from 0xFF to 0x00.
- R5: The step selector addresses entry 8 + `step_sel`. Selector values 6 (entry 14) and 7 (entry 15) change nothing, and a step never alters any entry other than the selected one.
- R6: When a write and a step target the same entry in one cycle, the written value is stored. When they target different entries, both take effect.
- R7: Entry 15 reads as {done, 000000, zero}. Bit 7 is done and bit 0 is zero. Bits 6 to 1 read 0 even after a write of ones.
- R8: The done bit becomes 1 after a cycle with `done_set` high or with a write to entry 15 whose bit 7 is 1. It then stays 1 until cleared.
- R9: `start_clr` clears the done bit at the next edge. It overrides `done_set` and a write to entry 15 in the same cycle.
- R10: With `zero_we` high, bit 0 of entry 15 takes `zero_in`. A write to entry 15 in the same cycle overrides it with bit 0 of `wr_data`.
- R11: `done_o` and `zero_o` always equal bits 7 and 0 of entry 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| step_en | input | 1 | Step strobe |
| step_sel | input | 3 | Step selector; targets entry 8 + step_sel |
| done_set | input | 1 | Software done strobe |
| start_clr | input | 1 | External done clear |
| zero_we | input | 1 | Zero-flag update strobe |
| zero_in | input | 1 | New zero-flag value |
| done_o | output | 1 | Done flag |
| zero_o | output | 1 | Zero flag |

## Verification
The bench builds the block with its default 8-bit data width. At this width, both wrap points of the index registers are one write and one step away: 0x00 stepping to 0xFF on a decrementer, and 0xFF stepping to 0x00 on an incrementer. The same cycles also reach every priority collision: a write against a step on one entry, the start clear against both software sets of done, and a flags write against the zero update. Each collision is driven in a single cycle and observed on the next.

// File: rtl/idxrf_pkg.sv
package idxrf_pkg;

    localparam int ADDR_W    = 4;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int SEL_W     = ADDR_W - 1;
    localparam int STEP_BASE = NUM_REGS / 2;
    localparam int DEC_FIRST = 8;
    localparam int DEC_LAST  = 10;
    localparam int INC_FIRST = 11;
    localparam int INC_LAST  = 13;
    localparam int LINK_IDX  = 14;
    localparam int FLAG_IDX  = 15;

    typedef enum logic [1:0] {
        RK_PLAIN = 2'd0,
        RK_DEC   = 2'd1,
        RK_INC   = 2'd2,
        RK_FLAGS = 2'd3
    } reg_kind_e;

    typedef enum logic {
        DS_RUNNING  = 1'b0,
        DS_FINISHED = 1'b1
    } done_state_e;

    function automatic reg_kind_e kind_of(input int idx);
        if (idx == FLAG_IDX)
            return RK_FLAGS;
        else if (idx >= DEC_FIRST && idx <= DEC_LAST)
            return RK_DEC;
        else if (idx >= INC_FIRST && idx <= INC_LAST)
            return RK_INC;
        else
            return RK_PLAIN;
    endfunction

endpackage

// File: rtl/idxrf_step_dec.sv
module idxrf_step_dec
    import idxrf_pkg::*;
(
    input  logic                step_en,
    input  logic [SEL_W-1:0]    step_sel,
    output logic [NUM_REGS-1:0] step_hit
);

    // Implied top address bit of 1: the selector reaches the upper half.
    logic [ADDR_W-1:0] step_addr;
    assign step_addr = {1'b1, step_sel};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        if (kind_of(i) == RK_DEC || kind_of(i) == RK_INC) begin : g_live
            assign step_hit[i] = step_en && (step_addr == ADDR_W'(i));
        end else begin : g_dead
            assign step_hit[i] = 1'b0;
        end
    end

endmodule

// File: rtl/idxrf_entry.sv
module idxrf_entry
    import idxrf_pkg::*;
#(
    parameter int        DATA_W = 8,
    parameter reg_kind_e KIND   = RK_PLAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_hit,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] stepped;
    logic [DATA_W-1:0] q_next;

    if (KIND == RK_DEC) begin : g_dec
        assign stepped = q - DATA_W'(1);
    end else if (KIND == RK_INC) begin : g_inc
        assign stepped = q + DATA_W'(1);
    end else begin : g_hold
        assign stepped = q;
    end

    // A write outranks a step on the same entry.
    always_comb begin
        if (wr_hit)
            q_next = wr_data;
        else if (step_hit)
            q_next = stepped;
        else
            q_next = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_next;
    end

endmodule

// File: rtl/idxrf_flags.sv
module idxrf_flags
    import idxrf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_set,
    input  logic              start_clr,
    input  logic              zero_we,
    input  logic              zero_in,
    output logic [DATA_W-1:0] flags_q,
    output logic              done_o,
    output logic              zero_o
);

    localparam int DONE_BIT = DATA_W - 1;
    localparam int ZERO_BIT = 0;

    done_state_e state_q;
    done_state_e state_d;
    logic        zero_q;
    logic        zero_d;

    // GO_HALT / GO_RUN transitions; start_clr outranks every set.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_RUNNING: begin
                if (!start_clr && (done_set || (wr_hit && wr_data[DONE_BIT])))
                    state_d = DS_FINISHED;
            end
            DS_FINISHED: begin
                if (start_clr || (wr_hit && !wr_data[DONE_BIT] && !done_set))
                    state_d = DS_RUNNING;
            end
            default: state_d = DS_RUNNING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DS_RUNNING;
        else
            state_q <= state_d;
    end

    // Direct flags write outranks the datapath zero update.
    always_comb begin
        if (wr_hit)
            zero_d = wr_data[ZERO_BIT];
        else if (zero_we)
            zero_d = zero_in;
        else
            zero_d = zero_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_q <= 1'b0;
        else
            zero_q <= zero_d;
    end

    always_comb begin
        flags_q           = '0;
        flags_q[DONE_BIT] = (state_q == DS_FINISHED);
        flags_q[ZERO_BIT] = zero_q;
        done_o            = (state_q == DS_FINISHED);
        zero_o            = zero_q;
    end

endmodule

// File: rtl/idxreg_file.sv
module idxreg_file
    import idxrf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_en,
    input  logic [2:0]        step_sel,
    input  logic              done_set,
    input  logic              start_clr,
    input  logic              zero_we,
    input  logic              zero_in,
    output logic              done_o,
    output logic              zero_o
);

    logic [DATA_W-1:0]   regs [NUM_REGS];
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] step_hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wdec
        assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    idxrf_step_dec u_step_dec (
        .step_en  (step_en),
        .step_sel (step_sel),
        .step_hit (step_hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (kind_of(i) == RK_FLAGS) begin : g_flags
            idxrf_flags #(.DATA_W(DATA_W)) u_flags (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_hit    (wr_hit[i]),
                .wr_data   (wr_data),
                .done_set  (done_set),
                .start_clr (start_clr),
                .zero_we   (zero_we),
                .zero_in   (zero_in),
                .flags_q   (regs[i]),
                .done_o    (done_o),
                .zero_o    (zero_o)
            );
        end else begin : g_data
            idxrf_entry #(.DATA_W(DATA_W), .KIND(kind_of(i))) u_entry (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (wr_hit[i]),
                .wr_data  (wr_data),
                .step_hit (step_hit[i]),
                .q        (regs[i])
            );
        end
    end

    always_comb rd_data = regs[rd_addr];

endmodule

// File: rtl/idxrf_chk.sv
module idxrf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              step_en,
    input logic [2:0]        step_sel,
    input logic              done_set,
    input logic              start_clr,
    input logic              zero_we,
    input logic              zero_in,
    input logic              done_o,
    input logic              zero_o
);

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !done_o);

    // R8
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_set && !start_clr) |=> done_o);

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_clr && !(wr_en && wr_addr == 4'd15)) |=> done_o);

    // R10
    zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_we && !(wr_en && wr_addr == 4'd15)) |=> (zero_o == $past(zero_in)));

    // R7
    flag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd15) |-> (rd_data[DATA_W-2:1] == '0));

    // R11
    flag_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd15) |-> (rd_data[DATA_W-1] == done_o && rd_data[0] == zero_o));

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && wr_addr != 4'd15) ##1 (rd_addr == $past(wr_addr)))
        |-> (rd_data == $past(wr_data)));

endmodule

bind idxreg_file idxrf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/idxreg_file_bench.sv
`timescale 1ns/1ps
module idxreg_file_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       step_en;
    logic [2:0] step_sel;
    logic       done_set;
    logic       start_clr;
    logic       zero_we;
    logic       zero_in;
    logic       done_o;
    logic       zero_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    idxreg_file u_idxreg_file (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .step_en(step_en), .step_sel(step_sel), .done_set(done_set),
        .start_clr(start_clr), .zero_we(zero_we), .zero_in(zero_in),
        .done_o(done_o), .zero_o(zero_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_addr = 0; wr_data = 0; step_en = 0; step_sel = 0;
        done_set = 0; start_clr = 0; zero_we = 0; zero_in = 0;
    endtask

    // One clock edge, then inputs return to idle 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic step(input logic [2:0] s);
        step_en = 1; step_sel = s;
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check($sformatf("R1 entry %0d", i), v, 8'h00);
        end
        check("R1 done_o", {7'd0, done_o}, 8'h00);
        check("R1 zero_o", {7'd0, zero_o}, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd7, 8'h81); wr(4'd14, 8'h5A);
        rd(4'd0, v);  check("R2 r0", v, 8'hA5);
        rd(4'd1, v);  check("R2 r1", v, 8'h3C);
        rd(4'd7, v);  check("R2 r7", v, 8'h81);
        rd(4'd14, v); check("R2 r14", v, 8'h5A);
    endtask

    task automatic t_decrement();
        logic [7:0] v;
        wr(4'd8, 8'h00); wr(4'd9, 8'h05); wr(4'd10, 8'h80);
        step(3'd0); step(3'd1); step(3'd2); step(3'd2);
        rd(4'd8, v);  check("R3 r8 wrap", v, 8'hFF);
        rd(4'd9, v);  check("R3 r9", v, 8'h04);
        rd(4'd10, v); check("R3 r10 twice", v, 8'h7E);
    endtask

    task automatic t_increment();
        logic [7:0] v;
        wr(4'd11, 8'hFF); wr(4'd12, 8'h10); wr(4'd13, 8'h7F);
        step(3'd3); step(3'd4); step(3'd5);
        rd(4'd11, v); check("R4 r11 wrap", v, 8'h00);
        rd(4'd12, v); check("R4 r12", v, 8'h11);
        rd(4'd13, v); check("R4 r13", v, 8'h80);
        rd(4'd9, v);  check("R5 r9 untouched", v, 8'h04);
    endtask

    task automatic t_dead_steps();
        logic [7:0] v;
        wr(4'd14, 8'h33);
        wr(4'd15, 8'h01);
        step(3'd6); step(3'd7);
        rd(4'd14, v); check("R5 r14 step ignored", v, 8'h33);
        rd(4'd15, v); check("R5 r15 step ignored", v, 8'h01);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wr(4'd9, 8'h20);
        wr_en = 1; wr_addr = 4'd9; wr_data = 8'h40; step_en = 1; step_sel = 3'd1;
        tick();
        rd(4'd9, v); check("R6 write beats step", v, 8'h40);
        wr(4'd12, 8'h02);
        wr_en = 1; wr_addr = 4'd0; wr_data = 8'h66; step_en = 1; step_sel = 3'd4;
        tick();
        rd(4'd0, v);  check("R6 parallel write", v, 8'h66);
        rd(4'd12, v); check("R6 parallel step", v, 8'h03);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        wr(4'd15, 8'hFF);
        rd(4'd15, v); check("R7 pad bits read 0", v, 8'h81);
        check("R11 done_o", {7'd0, done_o}, 8'h01);
        check("R11 zero_o", {7'd0, zero_o}, 8'h01);
        start_clr = 1; tick();
        rd(4'd15, v); check("R9 start clears done", v, 8'h01);
        done_set = 1; tick();
        tick(); tick();
        rd(4'd15, v); check("R8 done set and held", v, 8'h81);
        start_clr = 1; done_set = 1; tick();
        check("R9 clear beats done_set", {7'd0, done_o}, 8'h00);
        start_clr = 1; wr_en = 1; wr_addr = 4'd15; wr_data = 8'h80; tick();
        check("R9 clear beats write", {7'd0, done_o}, 8'h00);
        zero_we = 1; zero_in = 0; tick();
        check("R10 zero load 0", {7'd0, zero_o}, 8'h00);
        zero_we = 1; zero_in = 1; tick();
        check("R10 zero load 1", {7'd0, zero_o}, 8'h01);
        zero_we = 1; zero_in = 1; wr_en = 1; wr_addr = 4'd15; wr_data = 8'h80; tick();
        rd(4'd15, v); check("R10 write beats zero_we", v, 8'h80);
        check("R8 write sets done", {7'd0, done_o}, 8'h01);
    endtask

    initial begin
        #20000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rd_addr = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_write_read();
        t_decrement();
        t_increment();
        t_dead_steps();
        t_collision();
        t_flags();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule